// File: doc/BRIEF.md
# CPU Interrupt Enable and Mask Controller

This block keeps the interrupt-enable state of a small 8-bit CPU core and decides, at the end of each instruction, whether an interrupt is taken and which one. It holds two global enable flip-flops and a 4-bit per-input mask. The mask is written through the I/O address space and cannot be read back. The instruction decoder reports enable, disable and non-maskable-return instructions as strobes in the cycle where that instruction completes. The controller answers with a one-hot grant one cycle later and shows the two flip-flop states on its outputs.

A maskable request passes two gates: its own mask bit and both global flip-flops. The non-maskable input is edge-triggered. It is latched until the next instruction boundary and wins over every maskable request. When an NMI is accepted, the second flip-flop keeps the first flip-flop's state, so a later non-maskable return can restore it. The vector fetch, the stacking of the return address and the bus timing belong to the core.

Top module: `intr_enable_ctrl`

## Requirements
- R1: After reset both flip-flops read 0, no grant is raised, and the mask holds only the INTR enable (mask bit 0 = 1, bits 1 to 3 = 0).
- R2: An I/O write to address 0xBB with `io_blk` low loads `io_data[3:0]` into the mask and is used from the next cycle on. The bit meanings are: bit 0 INTR, bit 1 RSTC, bit 2 RSTB, bit 3 RSTA.
- R3: An I/O write to 0xBB with `io_blk` high, or a write to any other address, leaves the mask unchanged.
- R4: A maskable request is accepted in an `instr_done` cycle only if its mask bit is 1 and both flip-flops are 1.
- R5: `ei_stb` with `instr_done` sets both flip-flops. No maskable request is accepted at the completion of that EI, so the earliest acceptance is at the completion of the next instruction.
- R6: `di_stb` with `instr_done` clears both flip-flops, and no maskable request is accepted in that cycle.
- R7: Accepting a maskable request clears both flip-flops.
- R8: A rising edge on `nmi` is latched and accepted at the next `instr_done`, whatever the enables are. Acceptance copies flip-flop 1 into flip-flop 2 and clears flip-flop 1. A level held high gives only one acceptance.
- R9: `retn_stb` with `instr_done` copies flip-flop 2 into flip-flop 1. An instruction completion with no strobe leaves both flip-flops as they are.
- R10: Grants appear in the cycle after the accepting `instr_done` and last one cycle. They are one-hot, with priority NMI first, then RSTA (`grant_irq[3]`), RSTB, RSTC and INTR (`grant_irq[0]`).
- R11: `ei_stb`, `di_stb` and `retn_stb` have no effect in a cycle where `instr_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_done | input | 1 | Instruction completes this cycle; requests are sampled |
| ei_stb | input | 1 | Completing instruction is an enable |
| di_stb | input | 1 | Completing instruction is a disable |
| retn_stb | input | 1 | Completing instruction is a non-maskable return |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O write address |
| io_data | input | 8 | I/O write data |
| io_blk | input | 1 | The write comes from a block-move instruction |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_req | input | 4 | Maskable requests: bit 3 RSTA, bit 2 RSTB, bit 1 RSTC, bit 0 INTR |
| grant_nmi | output | 1 | NMI accepted (one-cycle pulse) |
| grant_irq | output | 4 | Maskable grant, one-hot, same bit order as `irq_req` |
| iff1 | output | 1 | Global enable flip-flop 1 |
| iff2 | output | 1 | Global enable flip-flop 2 |

## Verification
Each result is due exactly one clock after the cycle that causes it: grants, flip-flop updates and mask loads are all registered once. A mask load first shows up in a grant at the next `instr_done` after that edge. The bench drives inputs on the falling edge and samples on the following falling edge, so every output is read one full edge after its stimulus. A behavioural model updated on each rising edge is compared every cycle. Directed checks read fixed expected values one tick after each stimulus, including the EI-blocked completion and the latched NMI edge.

// File: rtl/intr_ctrl_pkg.sv
// Shared definitions for the interrupt enable controller.
// Assumes at most one instruction-class strobe matters per completion;
// when several are raised, disable wins over enable, and enable over return.
package intr_ctrl_pkg;

    localparam int unsigned NUM_MASKABLE = 4;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_EN    = 2'd1,
        OP_DIS   = 2'd2,
        OP_NRET  = 2'd3
    } iff_op_e;

    // Reduce the three decoder strobes to one operation, qualified by completion.
    function automatic iff_op_e decode_op(input logic done, input logic en,
                                          input logic dis, input logic nret);
        if (!done)     return OP_PLAIN;
        else if (dis)  return OP_DIS;
        else if (en)   return OP_EN;
        else if (nret) return OP_NRET;
        else           return OP_PLAIN;
    endfunction

endpackage

// File: rtl/intr_mask_reg.sv
// Write-only per-input mask register in the I/O space.
// Loads the low N_IRQ data bits on a single-transfer write to MASK_ADDR;
// writes flagged as block-move transfers are discarded.
module intr_mask_reg #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned N_IRQ     = 4,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hBB,
    parameter logic [N_IRQ-1:0]  MASK_RST  = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_data,
    input  logic              io_blk,
    output logic [N_IRQ-1:0]  mask
);

    logic load;
    logic unused_hi_data;

    // Decode an accepted mask write.
    assign load = io_wr && !io_blk && (io_addr == MASK_ADDR);
    assign unused_hi_data = ^io_data[DATA_W-1:N_IRQ];

    // Hold the mask; reset leaves only the lowest-priority input enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= MASK_RST;
        else if (load)
            mask <= io_data[N_IRQ-1:0];
    end

endmodule

// File: rtl/intr_nmi_latch.sv
// Edge detector and pending latch for the non-maskable input.
// A rising edge is remembered until the next instruction completion, and it
// is taken in that same completion cycle if the edge arrives there.
module intr_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi,
    input  logic instr_done,
    output logic take_nmi
);

    logic nmi_q;
    logic pend_q;
    logic rise;

    // Detect the rising edge and combine it with an older pending one.
    assign rise     = nmi && !nmi_q;
    assign take_nmi = instr_done && (pend_q || rise);

    // Track the previous input level and the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            nmi_q  <= nmi;
            pend_q <= (pend_q || rise) && !instr_done;
        end
    end

endmodule

// File: rtl/intr_iff_unit.sv
// The two global enable flip-flops.
// Applies the completing instruction's effect first and the acceptance on top
// of it. Reports whether maskable requests may be sampled this cycle.
module intr_iff_unit
    import intr_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  iff_op_e op,
    input  logic    take_nmi,
    input  logic    take_mask,
    output logic    mask_armed,
    output logic    iff1,
    output logic    iff2
);

    logic op1, op2;
    logic nx1, nx2;

    // Maskable sampling needs both flip-flops set and neither EI nor DI completing.
    assign mask_armed = iff1 && iff2 && (op != OP_EN) && (op != OP_DIS);

    // Effect of the completing instruction.
    always_comb begin
        op1 = iff1;
        op2 = iff2;
        unique case (op)
            OP_EN:    begin op1 = 1'b1; op2 = 1'b1; end
            OP_DIS:   begin op1 = 1'b0; op2 = 1'b0; end
            OP_NRET:  op1 = iff2;
            default:  ;
        endcase
    end

    // Effect of an acceptance, applied after the instruction's effect.
    always_comb begin
        nx1 = op1;
        nx2 = op2;
        if (take_nmi) begin
            nx1 = 1'b0;
            nx2 = op1;
        end else if (take_mask) begin
            nx1 = 1'b0;
            nx2 = 1'b0;
        end
    end

    // State registers; both start disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else begin
            iff1 <= nx1;
            iff2 <= nx2;
        end
    end

endmodule

// File: rtl/intr_prio_pick.sv
// Fixed-priority one-hot picker: the highest index wins.
// Assumes N_IRQ >= 2.
module intr_prio_pick #(
    parameter int unsigned N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] req,
    output logic [N_IRQ-1:0] pick
);

    logic [N_IRQ-1:0] above;

    assign above[N_IRQ-1] = 1'b0;
    assign pick[N_IRQ-1]  = req[N_IRQ-1];

    // Chain: a bit is blocked when any higher bit requests.
    for (genvar g = 0; g < N_IRQ - 1; g++) begin : g_chain
        assign above[g] = above[g+1] || req[g+1];
        assign pick[g]  = req[g] && !above[g];
    end

endmodule

// File: rtl/intr_enable_ctrl.sv
// Interrupt enable and mask controller.
// Samples requests on each instruction completion, grants the NMI over any
// maskable request, and registers the grants for one cycle.
// Assumes the decoder strobes are valid in the completion cycle.
module intr_enable_ctrl
    import intr_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned N_IRQ     = NUM_MASKABLE,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hBB,
    parameter logic [N_IRQ-1:0]  MASK_RST  = {{(N_IRQ-1){1'b0}}, 1'b1}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              retn_stb,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_data,
    input  logic              io_blk,
    input  logic              nmi,
    input  logic [N_IRQ-1:0]  irq_req,
    output logic              grant_nmi,
    output logic [N_IRQ-1:0]  grant_irq,
    output logic              iff1,
    output logic              iff2
);

    iff_op_e          op;
    logic [N_IRQ-1:0] mask;
    logic [N_IRQ-1:0] eligible;
    logic [N_IRQ-1:0] pick;
    logic             take_nmi;
    logic             take_mask;
    logic             mask_armed;

    // Reduce the decoder strobes to one operation.
    assign op = decode_op(instr_done, ei_stb, di_stb, retn_stb);

    intr_mask_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_IRQ(N_IRQ),
        .MASK_ADDR(MASK_ADDR), .MASK_RST(MASK_RST)
    ) u_mask (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_data(io_data), .io_blk(io_blk), .mask(mask)
    );

    intr_nmi_latch u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi(nmi),
        .instr_done(instr_done), .take_nmi(take_nmi)
    );

    intr_iff_unit u_iff (
        .clk(clk), .rst_n(rst_n), .op(op), .take_nmi(take_nmi),
        .take_mask(take_mask), .mask_armed(mask_armed),
        .iff1(iff1), .iff2(iff2)
    );

    // First enable level: each request is gated by its mask bit.
    assign eligible = irq_req & mask;

    intr_prio_pick #(.N_IRQ(N_IRQ)) u_pick (.req(eligible), .pick(pick));

    // Second enable level plus the NMI override.
    assign take_mask = instr_done && !take_nmi && mask_armed && (|eligible);

    // One-cycle registered grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_nmi <= 1'b0;
            grant_irq <= '0;
        end else begin
            grant_nmi <= take_nmi;
            grant_irq <= take_mask ? pick : '0;
        end
    end

endmodule

// File: rtl/intr_enable_ctrl_chk.sv
// Port-level temporal checks for the interrupt enable controller.
module intr_enable_ctrl_chk #(
    parameter int unsigned N_IRQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_done,
    input logic             ei_stb,
    input logic             di_stb,
    input logic             retn_stb,
    input logic             grant_nmi,
    input logic [N_IRQ-1:0] grant_irq,
    input logic             iff1,
    input logic             iff2
);

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_nmi, grant_irq}));

    // R10
    grant_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_done |=> (!grant_nmi && grant_irq == '0));

    // R4
    mask_grant_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_irq != '0) |-> $past(iff1 && iff2));

    // R7
    mask_grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_irq != '0) |-> (!iff1 && !iff2));

    // R8
    nmi_saves_iff1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_nmi && !$past(ei_stb || di_stb || retn_stb)) |-> (!iff1 && iff2 == $past(iff1)));

    // R5
    ei_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && ei_stb && !di_stb) |=> (iff2 && (iff1 || grant_nmi) && grant_irq == '0));

    // R6
    di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && di_stb) |=> (!iff1 && !iff2 && grant_irq == '0));

    // R11
    strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_done |=> (iff1 == $past(iff1) && iff2 == $past(iff2)));

endmodule

bind intr_enable_ctrl intr_enable_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/test_intr_enable_ctrl.sv
// Self-checking bench: a behavioural model compared every cycle plus directed checks.
module test_intr_enable_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_done = 1'b0, ei_stb = 1'b0, di_stb = 1'b0, retn_stb = 1'b0;
    logic       io_wr = 1'b0, io_blk = 1'b0, nmi = 1'b0;
    logic [7:0] io_addr = 8'h00, io_data = 8'h00;
    logic [3:0] irq_req = 4'h0;
    logic       grant_nmi, iff1, iff2;
    logic [3:0] grant_irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // Behavioural model state.
    int  m_i1, m_i2, m_mask, m_prev, m_pend, m_gn, m_gi;

    intr_enable_ctrl i_intr_enable_ctrl (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ei_stb(ei_stb),
        .di_stb(di_stb), .retn_stb(retn_stb), .io_wr(io_wr), .io_addr(io_addr),
        .io_data(io_data), .io_blk(io_blk), .nmi(nmi), .irq_req(irq_req),
        .grant_nmi(grant_nmi), .grant_irq(grant_irq), .iff1(iff1), .iff2(iff2)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model: the next state from the requirements, one rising edge at a time.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_i1 = 0; m_i2 = 0; m_mask = 1; m_prev = 0; m_pend = 0; m_gn = 0; m_gi = 0;
        end else begin
            int n1, n2, rise, pe, act;
            rise = (nmi && !m_prev) ? 1 : 0;
            m_prev = nmi;
            pe = m_pend | rise;
            m_gn = 0; m_gi = 0;
            n1 = m_i1; n2 = m_i2;
            if (instr_done) begin
                if (di_stb) begin n1 = 0; n2 = 0; end
                else if (ei_stb) begin n1 = 1; n2 = 1; end
                else if (retn_stb) n1 = m_i2;
                if (pe != 0) begin
                    m_gn = 1; n2 = n1; n1 = 0;
                end else if (!ei_stb && !di_stb && m_i1 == 1 && m_i2 == 1) begin
                    act = irq_req & m_mask;
                    for (int k = 3; k >= 0; k--)
                        if (m_gi == 0 && act[k]) m_gi = 1 << k;
                    if (m_gi != 0) begin n1 = 0; n2 = 0; end
                end
                m_pend = 0;
            end else begin
                m_pend = pe;
            end
            m_i1 = n1; m_i2 = n2;
            if (io_wr && !io_blk && io_addr == 8'hBB) m_mask = io_data[3:0];
        end
    end

    // Every-cycle comparison with the model.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            checks++;
            if ({iff1, iff2} != {m_i1[0], m_i2[0]}) begin
                fails++;
                $display("FAIL R4 R5 R6 R7 R8 R9 flip-flops: actual %b%b expected %0d%0d",
                         iff1, iff2, m_i1, m_i2);
            end
            checks++;
            if ({grant_nmi, grant_irq} != {m_gn[0], m_gi[3:0]}) begin
                fails++;
                $display("FAIL R10 grant: actual %b_%b expected %0d_%b",
                         grant_nmi, grant_irq, m_gn, m_gi[3:0]);
            end
        end
    end

    task automatic tick(input logic d, input logic e, input logic di, input logic r);
        instr_done = d; ei_stb = e; di_stb = di; retn_stb = r;
        @(negedge clk);
        instr_done = 0; ei_stb = 0; di_stb = 0; retn_stb = 0;
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] dat, input logic blk);
        io_wr = 1; io_addr = a; io_data = dat; io_blk = blk;
        @(negedge clk);
        io_wr = 0; io_blk = 0;
    endtask

    task automatic chk(input string rq, input logic e1, input logic e2,
                       input logic en, input logic [3:0] eg);
        checks++;
        if ({iff1, iff2, grant_nmi, grant_irq} != {e1, e2, en, eg}) begin
            fails++;
            $display("FAIL %s: actual iff=%b%b nmi=%b irq=%b expected iff=%b%b nmi=%b irq=%b",
                     rq, iff1, iff2, grant_nmi, grant_irq, e1, e2, en, eg);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset", 0, 0, 0, 4'b0000);
        irq_req = 4'b0001;
        tick(1, 0, 0, 0);  chk("R4 disabled", 0, 0, 0, 4'b0000);
        tick(1, 1, 0, 0);  chk("R5 ei blocks own completion", 1, 1, 0, 4'b0000);
        tick(1, 0, 0, 0);  chk("R1 R7 intr taken", 0, 0, 0, 4'b0001);
        tick(0, 0, 0, 0);  chk("R10 one cycle", 0, 0, 0, 4'b0000);
        irq_req = 4'b1000;
        tick(1, 1, 0, 0);
        tick(1, 0, 0, 0);  chk("R1 R9 rsta masked", 1, 1, 0, 4'b0000);
        io_write(8'hBB, 8'h0F, 1);
        io_write(8'hBA, 8'h0F, 0);
        tick(1, 0, 0, 0);  chk("R3 ignored writes", 1, 1, 0, 4'b0000);
        io_write(8'hBB, 8'h0C, 0);
        irq_req = 4'b1111;
        tick(1, 0, 0, 0);  chk("R2 R10 rsta wins", 0, 0, 0, 4'b1000);
        irq_req = 4'b0111;
        tick(1, 1, 0, 0);
        tick(1, 0, 0, 0);  chk("R2 R10 rstb via mask", 0, 0, 0, 4'b0100);
        tick(1, 1, 0, 0);
        irq_req = 4'b1111; nmi = 1;
        tick(1, 0, 0, 0);  chk("R8 R10 nmi wins", 0, 1, 1, 4'b0000);
        tick(1, 0, 0, 0);  chk("R4 R8 held level", 0, 1, 0, 4'b0000);
        tick(1, 0, 0, 1);  chk("R9 retn restores", 1, 1, 0, 4'b0000);
        tick(1, 0, 1, 0);  chk("R6 di clears", 0, 0, 0, 4'b0000);
        nmi = 0;
        tick(0, 0, 0, 0);
        nmi = 1;
        tick(0, 0, 0, 0);  chk("R8 edge latched", 0, 0, 0, 4'b0000);
        tick(1, 0, 0, 0);  chk("R8 nmi while disabled", 0, 0, 1, 4'b0000);
        tick(0, 1, 0, 0);  chk("R11 ei without completion", 0, 0, 0, 4'b0000);
        tick(1, 1, 0, 0);
        tick(1, 1, 0, 0);  chk("R5 second ei blocks", 1, 1, 0, 4'b0000);
        tick(0, 0, 1, 0);  chk("R11 di without completion", 1, 1, 0, 4'b0000);
        tick(1, 0, 0, 0);  chk("R5 R10 taken after next", 0, 0, 0, 4'b1000);
        nmi = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule